// File: doc/BRIEF.md
# Two-Phase Bus Arbiter with Look-Ahead Warning

This block shares one memory bus between a video fetch engine and a CPU. It divides the pixel clock by eight to form a bus cycle. The video side owns the first half of each bus cycle and the CPU owns the second half. The video side can reserve the second half of a run of upcoming bus cycles by posting a request. The request gives the number of cycles to wait and the length of the run.

Once a run is accepted, the block drops its bus-available output at once. That output drives the CPU's ready input. The CPU may be in a burst of up to three writes, during which it ignores ready, so every run waits at least three full bus cycles with bus-available low before the first stolen half. A request with a shorter wait is pushed back to that minimum. During each stolen cycle, the address-enable output stays low through the second half so that the video side keeps the bus. The video side's driver enable is the inverse of address-enable.

Top module: `bus_phase_arbiter`

## Requirements
- R1: A bus cycle is eight pixel clocks. `phi0` is 0 on divider counts 0 to 3 and 1 on counts 4 to 7. The divider starts at count 0 after reset.
- R2: With no run pending, `ba` is 1 and `aec` follows `phi0`: 0 in the first half and 1 in the second half.
- R3: `drv_oe` is always the inverse of `aec`, so the video drivers are released whenever `aec` is 1.
- R4: A request is taken at the clock edge that ends a bus cycle (divider count 7) when no run is pending and `sched_len` is non-zero. `ba` goes to 0 at the start of the next bus cycle, numbered cycle 1.
- R5: With an effective gap `Ge`, `aec` is held at 0 through the second half of cycles `Ge+1` to `Ge+sched_len`, counted from cycle 1. The first half of those cycles is unchanged.
- R6: `ba` stays 0 across the whole run of back-to-back stolen cycles. It returns to 1 at the start of the cycle after the last stolen one.
- R7: `Ge` is `max(sched_gap, LEAD)` with `LEAD` = 3. A request with a gap below 3 is deferred so that `ba` has been 0 for at least three full cycles before any stolen half.
- R8: A request has no effect in any of these cases: `sched_valid` is high at a divider count other than 7, `sched_len` is 0, or a run is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_valid | input | 1 | Steal request strobe |
| sched_gap | input | GAP_W | Requested cycles of warning before the first stolen half |
| sched_len | input | LEN_W | Number of consecutive cycles whose second half is stolen |
| phi0 | output | 1 | Bus clock: 1 during the second half of each bus cycle |
| ba | output | 1 | Bus available to the CPU in the second half (to CPU ready) |
| aec | output | 1 | Address enable: 0 while the video side owns the bus |
| drv_oe | output | 1 | Video address and data driver enable |

## Verification
The assertions assume that the only way a stolen half can occur is through a request taken while `ba` is high. They also assume that reset places the divider at count 0. Given that, the ordering rules reduce to counting pixel clocks since `ba` fell and to looking at `phi0` edges.

The stimulus drives requests only on falling clock edges. It finds the bus-cycle boundary by watching `phi0`. It places each strobe on count 7, except in the off-boundary cases, which are meant to be ignored. The sweep covers every gap from 0 to 7 and every run length from 1 to 4. It also covers a zero-length request, an off-boundary strobe, and a second request posted while a run is pending.

// File: rtl/bus_phase_arbiter.sv
module bus_phase_arbiter #(
  parameter int LEAD  = 3,
  parameter int GAP_W = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sched_valid,
  input  logic [GAP_W-1:0] sched_gap,
  input  logic [LEN_W-1:0] sched_len,
  output logic             phi0,
  output logic             ba,
  output logic             aec,
  output logic             drv_oe
);
  localparam logic [GAP_W-1:0] LeadMin = GAP_W'(LEAD);

  logic [2:0]       pix;
  logic             busy;
  logic [GAP_W-1:0] lead;
  logic [LEN_W-1:0] run;

  wire cyc_end = (pix == 3'd7);
  wire take    = cyc_end && !busy && sched_valid && (sched_len != '0);
  wire steal   = busy && (lead == '0);
  wire [GAP_W-1:0] gap_eff = (sched_gap < LeadMin) ? LeadMin : sched_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix  <= '0;
      busy <= 1'b0;
      lead <= '0;
      run  <= '0;
    end else begin
      pix <= pix + 3'd1;
      if (take) begin
        busy <= 1'b1;
        lead <= gap_eff;
        run  <= sched_len;
      end else if (cyc_end && busy) begin
        if (lead != '0)
          lead <= lead - 1'b1;
        else if (run == LEN_W'(1))
          busy <= 1'b0;
        else
          run <= run - 1'b1;
      end
    end
  end

  assign phi0   = pix[2];
  assign ba     = !busy;
  assign aec    = phi0 && !steal;
  assign drv_oe = !aec;
endmodule

// File: rtl/bus_phase_arbiter_chk.sv
module bus_phase_arbiter_chk #(
  parameter int LEAD = 3
) (
  input logic clk,
  input logic rst_n,
  input logic phi0,
  input logic ba,
  input logic aec,
  input logic drv_oe
);
  localparam int MinLow = 8 * LEAD + 4;
  logic [7:0] low_clks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_clks <= '0;
    else if (ba)             low_clks <= '0;
    else if (low_clks != '1) low_clks <= low_clks + 8'd1;
  end

  a_r2_first_half_video: assert property (@(posedge clk) disable iff (!rst_n)
    !phi0 |-> !aec);
  a_r2_idle_cpu_half: assert property (@(posedge clk) disable iff (!rst_n)
    (ba && phi0) |-> aec);
  a_r7_lead_before_steal: assert property (@(posedge clk) disable iff (!rst_n)
    (phi0 && !aec) |-> (low_clks >= 8'(MinLow)));
  a_r6_ba_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ba) |-> $fell(phi0));
  a_r1_aec_on_phase_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aec) |-> !$stable(phi0));
  a_r3_drivers_released: assert property (@(posedge clk) disable iff (!rst_n)
    aec |-> !drv_oe);
endmodule

bind bus_phase_arbiter bus_phase_arbiter_chk #(.LEAD(LEAD)) chk_i (
  .clk(clk), .rst_n(rst_n), .phi0(phi0), .ba(ba), .aec(aec), .drv_oe(drv_oe)
);

// File: tb/bus_phase_arbiter_tb_top.sv
module bus_phase_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sched_valid = 1'b0;
  logic [3:0] sched_gap = '0;
  logic [3:0] sched_len = '0;
  logic phi0, ba, aec, drv_oe;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bus_phase_arbiter #(.LEAD(3), .GAP_W(4), .LEN_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .sched_valid(sched_valid), .sched_gap(sched_gap),
    .sched_len(sched_len), .phi0(phi0), .ba(ba), .aec(aec), .drv_oe(drv_oe)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align();
    do @(negedge clk); while (phi0 !== 1'b1);
    do @(negedge clk); while (phi0 !== 1'b0);
  endtask

  // Called at pixel 0 of a cycle; checks both halves and returns at pixel 0 of next cycle.
  task automatic chk_cycle(input logic exp_ba, input logic exp_steal, input string req,
                           input int inj_gap, input int inj_len, input logic inject);
    step(1);
    chk(phi0, 1'b0, "R1", "phi0 first half");
    chk(aec, 1'b0, "R2", "aec first half");
    chk(ba, exp_ba, req, "ba first half");
    step(4);
    chk(phi0, 1'b1, "R1", "phi0 second half");
    chk(aec, !exp_steal, req, "aec second half");
    chk(drv_oe, exp_steal, "R3", "drv_oe second half");
    chk(ba, exp_ba, req, "ba second half");
    if (inject) begin
      step(2);
      sched_valid = 1'b1; sched_gap = 4'(inj_gap); sched_len = 4'(inj_len);
      step(1);
      sched_valid = 1'b0;
    end else begin
      step(3);
    end
  endtask

  task automatic run_case(input int g, input int l, input logic busy_inject);
    int ge;
    ge = (g < 3) ? 3 : g;
    align();
    step(7);
    sched_valid = 1'b1; sched_gap = 4'(g); sched_len = 4'(l);
    step(1);
    sched_valid = 1'b0;
    for (int c = 1; c <= ge + l + 2; c++) begin
      logic eb, es;
      eb = !(c <= ge + l);
      es = (c > ge) && (c <= ge + l);
      chk_cycle(eb, es, (c <= ge) ? ((g < 3) ? "R7" : "R4") : (es ? "R5" : "R6"),
                0, 5, busy_inject && c == 1);
    end
    if (busy_inject) chk(ba, 1'b1, "R8", "ba after ignored busy request");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk(ba, 1'b1, "R2", "ba in reset");
    chk(drv_oe, !aec, "R3", "drv_oe in reset");
    rst_n = 1'b1;
    step(1);
    chk(phi0, 1'b0, "R1", "phi0 after reset");
    chk(aec, 1'b0, "R2", "aec after reset");
    chk(drv_oe, 1'b1, "R3", "drv_oe after reset");
    step(3);
    chk(phi0, 1'b1, "R1", "phi0 at count 4");
    chk(aec, 1'b1, "R2", "aec idle second half");
    chk(drv_oe, 1'b0, "R3", "drv_oe idle second half");

    for (int g = 0; g <= 7; g++)
      for (int l = 1; l <= 4; l++)
        run_case(g, l, 1'b0);

    // R8: zero-length request at the boundary
    align(); step(7);
    sched_valid = 1'b1; sched_gap = 4'd0; sched_len = 4'd0;
    step(1); sched_valid = 1'b0;
    for (int c = 0; c < 6; c++) chk_cycle(1'b1, 1'b0, "R8", 0, 0, 1'b0);

    // R8: strobes at every non-boundary count
    for (int p = 0; p < 7; p++) begin
      align(); step(p);
      sched_valid = 1'b1; sched_gap = 4'd3; sched_len = 4'd2;
      step(1); sched_valid = 1'b0;
      step(7 - p);
      for (int c = 0; c < 6; c++) chk_cycle(1'b1, 1'b0, "R8", 0, 0, 1'b0);
    end

    // R8: request posted while a run is pending leaves the timeline intact
    run_case(4, 2, 1'b1);
    run_case(0, 3, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule